// File: doc/BRIEF.md
# Address-Gated Serial Divider Loader

This block sits between a host controller and the reference, main and swallow divider latches of a frequency synthesizer. The host shares a three-wire serial bus (a select strobe, a shift clock and a data line) among several modules and picks one of them with a 3-bit address. When the address carries this block's own code, shift-clock edges move data bits into a 32-bit frame register. A rising edge on the select strobe then copies the frame into the divider outputs, but only if the last bit of the frame is a 1. The block also returns the synthesizer's lock indication to the host as a status flag and drives a complementary fault output.

All serial inputs are asynchronous to the system clock. They pass through a two-flop synchronizer before edge detection, so a host bit period must span several system clocks. A state machine with three states controls shifting and committing. `ST_IDLE` is the state while the address does not match. `ST_ARMED` is the state while it matches and bits may be shifted. `ST_COMMIT` lasts one cycle, during which the divider outputs are loaded. The transitions are:
- IDLE to ARMED when the address matches.
- ARMED to IDLE when the address stops matching.
- ARMED to COMMIT on a select-strobe rising edge while the last frame bit is 1.
- COMMIT to ARMED, or to IDLE if the address has meanwhile changed.

Top module: `sdl_top`

## Requirements
- R1: After reset the R, N and A outputs are all zero, the lock flag is low and the fault output is high.
- R2: Shift-clock edges are acted on only while `addr_i` equals 3'b010 (`addr_i[0]` low, `addr_i[1]` high, `addr_i[2]` low). Bits clocked while any other code is present do not enter the frame.
- R3: Each low-to-high transition of the shift clock moves the data bit into bit 0 of a 32-bit frame register. When more than 32 bits are clocked in, only the last 32 count.
- R4: The frame is sent in this order:
  - the R value, 14 bits, most significant bit first;
  - then the N value, 10 bits, most significant bit first;
  - then the A value, 7 bits, most significant bit first;
  - then one control bit.

  So after 32 shifts, R is in frame[31:18], N in frame[17:8], A in frame[7:1] and the control bit in frame[0].
- R5: A rising edge of the select strobe, while the address matches and the control bit is 1, loads R, N and A from the frame. The new values appear within 5 system clocks of the edge reaching the synchronizer.
- R6: A select-strobe edge while the control bit is 0 leaves the outputs unchanged.
- R7: The select strobe is ignored while the address does not match. If the strobe is already high when the address starts to match, that level does not commit the frame.
- R8: The lock flag follows the lock-detect input through a two-flop synchronizer. The fault output is always its inverse.
- R9: When a shift-clock edge and a select-strobe edge are detected in the same cycle, the commit takes precedence and that shift-clock edge does not shift the frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 3 | Module select address from the host |
| sel_i | input | 1 | Select strobe; a rising edge commits the frame |
| sclk_i | input | 1 | Serial shift clock |
| sdat_i | input | 1 | Serial data bit |
| lock_det_i | input | 1 | Lock indication from the phase detector |
| r_div_o | output | 14 | Reference divider value |
| n_div_o | output | 10 | Main divider value |
| a_div_o | output | 7 | Swallow divider value |
| lock_flag_o | output | 1 | Status to host, high when locked |
| fault_o | output | 1 | High while the loop is out of lock |

## Verification
The hardest situation to reach from the ports is a shift-clock edge and a select-strobe edge landing in the same system cycle. The bench raises both lines on the same clock. Because the two lines share one synchronizer, their edges are detected together, and the committed value then shows whether that edge slipped an extra bit into the frame. A second hard case is a frame split across an address change. The bench sends 28 bits, switches to a neighbouring address, clocks four conflicting bits, then returns and sends the last four bits. Only a design that truly drops the off-address bits commits the intended value.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
    localparam int SYNC_DEPTH = 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_COMMIT = 2'd2
    } ldr_state_e;
endpackage

// File: rtl/sdl_sync.sv
module sdl_sync #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    import sdl_pkg::*;

    logic [WIDTH-1:0] stage_q [SYNC_DEPTH];

    generate
        for (genvar s = 0; s < SYNC_DEPTH; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= async_i;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[SYNC_DEPTH-1];
endmodule

// File: rtl/sdl_ctrl.sv
module sdl_ctrl #(
    parameter int         ADDR_W  = 3,
    parameter logic [2:0] MY_ADDR = 3'b010
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                sel_s,
    input  logic                sclk_s,
    input  logic                ctrl_bit_i,
    output logic                shift_en_o,
    output logic                commit_o,
    output sdl_pkg::ldr_state_e state_o
);
    import sdl_pkg::*;

    ldr_state_e state_q, state_d;
    logic       sel_prev_q, sclk_prev_q;
    logic       hit, sel_rise, sclk_rise;

    assign hit       = (addr_i == MY_ADDR[ADDR_W-1:0]);
    assign sel_rise  = sel_s & ~sel_prev_q;
    assign sclk_rise = sclk_s & ~sclk_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_prev_q  <= 1'b0;
            sclk_prev_q <= 1'b0;
        end else begin
            sel_prev_q  <= sel_s;
            sclk_prev_q <= sclk_s;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (hit) state_d = ST_ARMED;
            ST_ARMED: begin
                if (!hit)                       state_d = ST_IDLE;
                else if (sel_rise && ctrl_bit_i) state_d = ST_COMMIT;
            end
            ST_COMMIT: state_d = hit ? ST_ARMED : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        shift_en_o = 1'b0;
        commit_o   = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_ARMED:  shift_en_o = hit && sclk_rise && !sel_rise;
            ST_COMMIT: commit_o = 1'b1;
            default:   ;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/sdl_frame.sv
module sdl_frame #(
    parameter int R_W = 14,
    parameter int N_W = 10,
    parameter int A_W = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           shift_en_i,
    input  logic           bit_i,
    input  logic           commit_i,
    output logic           ctrl_bit_o,
    output logic [R_W-1:0] r_o,
    output logic [N_W-1:0] n_o,
    output logic [A_W-1:0] a_o
);
    localparam int FRAME_W = R_W + N_W + A_W + 1;
    localparam int A_LO    = 1;
    localparam int N_LO    = A_LO + A_W;
    localparam int R_LO    = N_LO + N_W;

    logic [FRAME_W-1:0] frame_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          frame_q <= '0;
        else if (shift_en_i) frame_q <= {frame_q[FRAME_W-2:0], bit_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_o <= '0;
            n_o <= '0;
            a_o <= '0;
        end else if (commit_i) begin
            r_o <= frame_q[R_LO +: R_W];
            n_o <= frame_q[N_LO +: N_W];
            a_o <= frame_q[A_LO +: A_W];
        end
    end

    assign ctrl_bit_o = frame_q[0];
endmodule

// File: rtl/sdl_top.sv
module sdl_top #(
    parameter int         ADDR_W  = 3,
    parameter logic [2:0] MY_ADDR = 3'b010,
    parameter int         R_W     = 14,
    parameter int         N_W     = 10,
    parameter int         A_W     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              sel_i,
    input  logic              sclk_i,
    input  logic              sdat_i,
    input  logic              lock_det_i,
    output logic [R_W-1:0]    r_div_o,
    output logic [N_W-1:0]    n_div_o,
    output logic [A_W-1:0]    a_div_o,
    output logic              lock_flag_o,
    output logic              fault_o
);
    import sdl_pkg::*;

    logic [3:0] sync_vec;
    logic       shift_en, commit, ctrl_bit;
    ldr_state_e st;

    sdl_sync #(.WIDTH(4)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({lock_det_i, sel_i, sclk_i, sdat_i}),
        .sync_o  (sync_vec)
    );

    sdl_ctrl #(.ADDR_W(ADDR_W), .MY_ADDR(MY_ADDR)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (addr_i),
        .sel_s      (sync_vec[2]),
        .sclk_s     (sync_vec[1]),
        .ctrl_bit_i (ctrl_bit),
        .shift_en_o (shift_en),
        .commit_o   (commit),
        .state_o    (st)
    );

    sdl_frame #(.R_W(R_W), .N_W(N_W), .A_W(A_W)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en_i (shift_en),
        .bit_i      (sync_vec[0]),
        .commit_i   (commit),
        .ctrl_bit_o (ctrl_bit),
        .r_o        (r_div_o),
        .n_o        (n_div_o),
        .a_o        (a_div_o)
    );

    assign lock_flag_o = sync_vec[3];
    assign fault_o     = ~sync_vec[3];
endmodule

// File: rtl/sdl_chk.sv
module sdl_chk #(
    parameter int         ADDR_W  = 3,
    parameter logic [2:0] MY_ADDR = 3'b010,
    parameter int         R_W     = 14,
    parameter int         N_W     = 10,
    parameter int         A_W     = 7
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   addr_i,
    input logic                lock_det_i,
    input logic [R_W-1:0]      r_div_o,
    input logic [N_W-1:0]      n_div_o,
    input logic [A_W-1:0]      a_div_o,
    input logic                lock_flag_o,
    input logic                fault_o,
    input sdl_pkg::ldr_state_e st,
    input logic                ctrl_bit
);
    import sdl_pkg::*;

    logic [1:0] cyc_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cyc_q <= '0;
        else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
    end

    // R5
    latch_only_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(r_div_o) && $stable(n_div_o) && $stable(a_div_o)) |-> $past(st) == ST_COMMIT);

    // R7
    commit_needs_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_COMMIT |-> $past(addr_i) == MY_ADDR[ADDR_W-1:0]);

    // R6
    commit_needs_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_COMMIT |-> ctrl_bit);

    // R5
    single_commit_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_COMMIT |=> st != ST_COMMIT);

    // R8
    lock_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_q >= 2'd2 |-> lock_flag_o == $past(lock_det_i, 2));

    // R8
    fault_inverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o != lock_flag_o);
endmodule

bind sdl_top sdl_chk #(
    .ADDR_W(ADDR_W), .MY_ADDR(MY_ADDR), .R_W(R_W), .N_W(N_W), .A_W(A_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_i      (addr_i),
    .lock_det_i  (lock_det_i),
    .r_div_o     (r_div_o),
    .n_div_o     (n_div_o),
    .a_div_o     (a_div_o),
    .lock_flag_o (lock_flag_o),
    .fault_o     (fault_o),
    .st          (st),
    .ctrl_bit    (ctrl_bit)
);

// File: tb/tb_sdl_top.sv
module tb_sdl_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] HIT = 3'b010;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr_i = 3'b000;
    logic        sel_i = 1'b0, sclk_i = 1'b0, sdat_i = 1'b0, lock_det_i = 1'b0;
    logic [13:0] r_div_o;
    logic [9:0]  n_div_o;
    logic [6:0]  a_div_o;
    logic        lock_flag_o, fault_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdl_top dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .sel_i(sel_i),
        .sclk_i(sclk_i), .sdat_i(sdat_i), .lock_det_i(lock_det_i),
        .r_div_o(r_div_o), .n_div_o(n_div_o), .a_div_o(a_div_o),
        .lock_flag_o(lock_flag_o), .fault_o(fault_o)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_div(input string req, input logic [13:0] r, input logic [9:0] n, input logic [6:0] a);
        check({req, " R"}, {18'd0, r_div_o}, {18'd0, r});
        check({req, " N"}, {22'd0, n_div_o}, {22'd0, n});
        check({req, " A"}, {25'd0, a_div_o}, {25'd0, a});
    endtask

    task automatic send_bit(input logic b);
        sdat_i = b;
        wait_cyc(3);
        sclk_i = 1'b1;
        wait_cyc(4);
        sclk_i = 1'b0;
        wait_cyc(3);
    endtask

    task automatic send_bits(input logic [31:0] v, input int hi, input int lo);
        for (int i = hi; i >= lo; i--) send_bit(v[i]);
    endtask

    task automatic pulse_sel();
        sel_i = 1'b1;
        wait_cyc(4);
        sel_i = 1'b0;
        wait_cyc(8);
    endtask

    task automatic t_reset();
        check_div("R1 reset", 14'd0, 10'd0, 7'd0);
        check("R1 lock flag", {31'd0, lock_flag_o}, 32'd0);
        check("R1 fault", {31'd0, fault_o}, 32'd1);
    endtask

    task automatic t_basic();
        addr_i = HIT;
        wait_cyc(4);
        send_bits({14'h2B6D, 10'h2F1, 7'h55, 1'b1}, 31, 0);
        pulse_sel();
        check_div("R3 R4 R5 load1", 14'h2B6D, 10'h2F1, 7'h55);
        send_bits({14'h0001, 10'h200, 7'h7F, 1'b1}, 31, 0);
        pulse_sel();
        check_div("R4 R5 load2", 14'h0001, 10'h200, 7'h7F);
    endtask

    task automatic t_ctrl_zero();
        send_bits({14'h1234, 10'h0AA, 7'h12, 1'b0}, 31, 0);
        pulse_sel();
        check_div("R6 ctrl zero", 14'h0001, 10'h200, 7'h7F);
    endtask

    task automatic t_sel_gating();
        send_bits({14'h3C3C, 10'h155, 7'h2A, 1'b1}, 31, 0);
        addr_i = 3'b100;
        wait_cyc(4);
        pulse_sel();
        check_div("R7 sel off-address", 14'h0001, 10'h200, 7'h7F);
        sel_i = 1'b1;
        wait_cyc(6);
        addr_i = HIT;
        wait_cyc(12);
        check_div("R7 sel level at match", 14'h0001, 10'h200, 7'h7F);
        sel_i = 1'b0;
        wait_cyc(6);
        pulse_sel();
        check_div("R7 sel after match", 14'h3C3C, 10'h155, 7'h2A);
    endtask

    task automatic t_addr_gating();
        logic [31:0] v;
        v = {14'h0F0F, 10'h333, 7'h66, 1'b1};
        send_bits(v, 31, 4);
        addr_i = 3'b011;
        wait_cyc(4);
        send_bits(32'h0000_0005, 3, 0);
        addr_i = HIT;
        wait_cyc(4);
        send_bits(v, 3, 0);
        pulse_sel();
        check_div("R2 split frame", 14'h0F0F, 10'h333, 7'h66);
    endtask

    task automatic t_overlong();
        send_bits(32'h0000_0015, 4, 0);
        send_bits({14'h2001, 10'h3FF, 7'h01, 1'b1}, 31, 0);
        pulse_sel();
        check_div("R3 overlong", 14'h2001, 10'h3FF, 7'h01);
    endtask

    task automatic t_coincident();
        send_bits({14'h1111, 10'h0F0, 7'h3C, 1'b1}, 31, 0);
        sdat_i = 1'b0;
        wait_cyc(3);
        sclk_i = 1'b1;
        sel_i  = 1'b1;
        wait_cyc(4);
        sclk_i = 1'b0;
        sel_i  = 1'b0;
        wait_cyc(8);
        check_div("R9 coincident", 14'h1111, 10'h0F0, 7'h3C);
    endtask

    task automatic t_lock();
        lock_det_i = 1'b1;
        wait_cyc(4);
        check("R8 locked flag", {31'd0, lock_flag_o}, 32'd1);
        check("R8 locked fault", {31'd0, fault_o}, 32'd0);
        lock_det_i = 1'b0;
        wait_cyc(4);
        check("R8 unlocked flag", {31'd0, lock_flag_o}, 32'd0);
        check("R8 unlocked fault", {31'd0, fault_o}, 32'd1);
    endtask

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(3);
        t_reset();
        t_basic();
        t_ctrl_zero();
        t_sel_gating();
        t_addr_gating();
        t_overlong();
        t_coincident();
        t_lock();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done == 1'b1);
            begin
                repeat (100000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule